// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair with Status Word

This block buffers the byte stream of an SPI controller in both directions. The CPU loads outgoing bytes into a transmit queue, which the serial engine drains one entry per pop. The serial engine deposits incoming bytes into a receive queue, which the CPU drains one entry per read. Each queue holds 64 entries by default.

A single 32-bit status word shows the state of both queues. It carries the receive fill level, the transmit free space, and empty and full flags for each queue. It also carries a flush control per queue, four sticky error flags and a summary error bit. A status write does three things:
- Writing 1 to a flush bit empties that queue.
- Writing 0 to a sticky flag clears it.
- Writing 1 to a sticky flag leaves it unchanged.

Top module: `spi_fifo_pair`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0x00400005. Both read-data outputs read zero.
- R2: Bytes written on the CPU transmit port appear on `eng_tx_data` in write order. `eng_tx_data` always shows the oldest entry, and an engine pop advances to the next one.
- R3: Bytes pushed by the engine appear on `cpu_rx_data` in push order. `cpu_rx_data` always shows the oldest entry, and a CPU read advances to the next one.
- R4: Status bits 29:23 hold the number of filled receive entries. Status bits 22:16 hold the number of free transmit entries, which is depth minus fill.
- R5: The level flags are transmit full (bit 3), transmit empty (bit 2), receive full (bit 1) and receive empty (bit 0). Each is 1 when the condition holds.
- R6: A CPU write to a full transmit queue is discarded, leaving the stored bytes intact. The write sets sticky transmit overflow (bit 7).
- R7: An engine pop from an empty transmit queue changes no state and sets sticky transmit underrun (bit 6). During that pop, `eng_tx_data` reads zero.
- R8: An engine push to a full receive queue is discarded, leaving the stored bytes intact. The push sets sticky receive overflow (bit 5).
- R9: A CPU read from an empty receive queue returns zero and sets sticky receive underrun (bit 4).
- R10: Status bit 8 reads 1 exactly when at least one of bits 7:4 is 1.
- R11: A status write clears each sticky flag whose write-data bit is 0 and keeps each flag whose bit is 1. When an error event and a clearing write fall in the same cycle, the flag ends up set.
- R12: Writing 1 to bit 15 flushes the receive queue, and writing 1 to bit 14 flushes the transmit queue. The flush bit reads 1 for the one cycle after the write. At the end of that cycle the queue becomes empty and the bit returns to 0. Pushes, pops, writes and reads of that queue during the pending cycle are dropped and raise no flag.
- R13: Flushing one queue leaves the other queue's contents and level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_tx_wr | input | 1 | CPU write strobe into the transmit queue |
| cpu_tx_data | input | 8 | CPU write byte |
| cpu_rx_rd | input | 1 | CPU read strobe from the receive queue |
| cpu_rx_data | output | 8 | Oldest receive byte, or zero when the queue is empty |
| eng_tx_pop | input | 1 | Engine pop strobe from the transmit queue |
| eng_tx_data | output | 8 | Oldest transmit byte, or zero when the queue is empty |
| eng_rx_push | input | 1 | Engine push strobe into the receive queue |
| eng_rx_data | input | 8 | Engine push byte |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 32 | Status word write data |
| stat_rdata | output | 32 | Status word read value |

## Verification
Corrupt pointers or a wrong count show at the ports on the next cycle in three ways:
- a level field that disagrees with the number of accepted bytes;
- a full or empty flag out of step with that field;
- a byte surfacing out of order.

The bench drives each queue to its boundaries. It fills a queue completely, overfills it and drains it, then compares the drained bytes one by one, so a dropped overflow byte that was nevertheless stored shows up within the drain. A flush that skips or delays its reset shows in the status word one cycle after the write. A sticky flag that is lost, cleared by a 1, or overridden by a same-cycle clear shows on the status read that immediately follows.

// File: rtl/spi_fifo_pkg.sv
// Shared constants and types for the SPI FIFO pair.
// Assumes a 32-bit status word whose bit positions are decoded by software.
package spi_fifo_pkg;
    localparam int ST_RXCNT_LSB = 23;
    localparam int ST_TXFREE_LSB = 16;
    localparam int ST_FIELD_W = 7;
    localparam int ST_RXFLUSH = 15;
    localparam int ST_TXFLUSH = 14;
    localparam int ST_ERR = 8;
    localparam int ST_STICKY_LSB = 4;
    localparam int ST_TXFULL = 3;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_RXFULL = 1;
    localparam int ST_RXEMPTY = 0;

    // Error pulses produced by one queue in a cycle
    typedef struct packed {
        logic ovf;
        logic unr;
    } fifo_evt_t;
endpackage

// File: rtl/fifo_store.sv
// Circular byte queue with flush, level outputs and error pulses.
// Assumes: flush has priority over push and pop; a push when full or a pop
// when empty is dropped and reported on evt; head reads zero when empty.
module fifo_store
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty,
    output fifo_evt_t        evt
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic do_push, do_pop;

    // Accept only in-range, non-flush accesses
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        evt.ovf = push && full && !flush;
        evt.unr = pop && empty && !flush;
        head    = empty ? '0 : mem[rd_ptr];
    end

    // Storage array write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and count update, flush resets all
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R12
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> (count == $past(count) + 1'b1));
    // R6
    drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/spi_fifo_ctl.sv
// Flush request bits and sticky error flags for both queues.
// Assumes: a flush bit lives exactly one cycle; a set event beats a clear write.
// Sticky order: [3] tx overflow, [2] tx underrun, [1] rx overflow, [0] rx underrun.
module spi_fifo_ctl
    import spi_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       wr_tx_flush,
    input  logic       wr_rx_flush,
    input  logic [3:0] wr_sticky,
    input  fifo_evt_t  tx_evt,
    input  fifo_evt_t  rx_evt,
    output logic       tx_flush,
    output logic       rx_flush,
    output logic [3:0] sticky
);
    logic [3:0] set_vec;

    // Gather error pulses into sticky order
    always_comb set_vec = {tx_evt.ovf, tx_evt.unr, rx_evt.ovf, rx_evt.unr};

    // Flush bits: set by a write of 1, cleared the cycle after
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flush <= 1'b0;
            rx_flush <= 1'b0;
        end else begin
            tx_flush <= tx_flush ? 1'b0 : (wr && wr_tx_flush);
            rx_flush <= rx_flush ? 1'b0 : (wr && wr_rx_flush);
        end
    end

    // Sticky flags: write-0 clears, events set with priority
    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= '0;
        else        sticky <= (wr ? (sticky & wr_sticky) : sticky) | set_vec;
    end

    // R12
    tx_flush_self_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> !tx_flush);
    // R12
    rx_flush_self_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> !rx_flush);
    // R6
    tx_ovf_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt.ovf |=> sticky[3]);
    // R9
    rx_unr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt.unr |=> sticky[0]);
    // R11
    keep_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_sticky[2] && sticky[2]) |=> sticky[2]);
endmodule

// File: rtl/spi_fifo_pair.sv
// Transmit and receive queues of an SPI controller behind one status word.
// Assumes DEPTH fits the 7-bit level fields and bytes are 8 bits wide.
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_tx_wr,
    input  logic [7:0]  cpu_tx_data,
    input  logic        cpu_rx_rd,
    output logic [7:0]  cpu_rx_data,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_data,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    input  logic        stat_wr,
    input  logic [31:0] stat_wdata,
    output logic [31:0] stat_rdata
);
    logic [CW-1:0] tx_count, rx_count;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_flush, rx_flush;
    logic [3:0] sticky;
    fifo_evt_t tx_evt, rx_evt;
    logic unused_wdata;

    assign unused_wdata = ^{stat_wdata[31:16], stat_wdata[13:8], stat_wdata[3:0]};

    spi_fifo_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(stat_wr),
        .wr_tx_flush(stat_wdata[ST_TXFLUSH]), .wr_rx_flush(stat_wdata[ST_RXFLUSH]),
        .wr_sticky(stat_wdata[ST_STICKY_LSB +: 4]),
        .tx_evt(tx_evt), .rx_evt(rx_evt),
        .tx_flush(tx_flush), .rx_flush(rx_flush), .sticky(sticky)
    );

    fifo_store #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(cpu_tx_wr), .push_data(cpu_tx_data), .pop(eng_tx_pop),
        .head(eng_tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty),
        .evt(tx_evt)
    );

    fifo_store #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_push), .push_data(eng_rx_data), .pop(cpu_rx_rd),
        .head(cpu_rx_data), .count(rx_count), .full(rx_full), .empty(rx_empty),
        .evt(rx_evt)
    );

    // Assemble the status word
    always_comb begin
        stat_rdata = '0;
        stat_rdata[ST_RXCNT_LSB +: ST_FIELD_W]  = ST_FIELD_W'(rx_count);
        stat_rdata[ST_TXFREE_LSB +: ST_FIELD_W] = ST_FIELD_W'(CW'(DEPTH) - tx_count);
        stat_rdata[ST_RXFLUSH] = rx_flush;
        stat_rdata[ST_TXFLUSH] = tx_flush;
        stat_rdata[ST_ERR]     = |sticky;
        stat_rdata[ST_STICKY_LSB +: 4] = sticky;
        stat_rdata[ST_TXFULL]  = tx_full;
        stat_rdata[ST_TXEMPTY] = tx_empty;
        stat_rdata[ST_RXFULL]  = rx_full;
        stat_rdata[ST_RXEMPTY] = rx_empty;
    end

    // R13
    rx_kept_on_tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !rx_flush && !eng_rx_push && !cpu_rx_rd) |=> $stable(rx_count));
endmodule

// File: tb/sim_spi_fifo_pair.sv
// Directed bench for spi_fifo_pair: one task per scenario, each self-checking.
module sim_spi_fifo_pair;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_tx_wr = 0, cpu_rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0, stat_wr = 0;
    logic [7:0] cpu_tx_data = 0, eng_rx_data = 0;
    logic [31:0] stat_wdata = 0;
    logic [7:0] cpu_rx_data, eng_tx_data;
    logic [31:0] stat_rdata;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_fifo_pair u0 (
        .clk(clk), .rst_n(rst_n), .cpu_tx_wr(cpu_tx_wr), .cpu_tx_data(cpu_tx_data),
        .cpu_rx_rd(cpu_rx_rd), .cpu_rx_data(cpu_rx_data), .eng_tx_pop(eng_tx_pop),
        .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    function automatic logic [6:0] rx_cnt(); return stat_rdata[29:23]; endfunction
    function automatic logic [6:0] tx_free(); return stat_rdata[22:16]; endfunction

    task automatic cpu_wr(input logic [7:0] b);
        @(negedge clk); cpu_tx_wr = 1; cpu_tx_data = b;
        @(negedge clk); cpu_tx_wr = 0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(negedge clk); eng_rx_push = 1; eng_rx_data = b;
        @(negedge clk); eng_rx_push = 0;
    endtask

    task automatic eng_pop_chk(input string req, input logic [7:0] exp);
        @(negedge clk); eng_tx_pop = 1; #0.5;
        chk_eq(req, {24'h0, eng_tx_data}, {24'h0, exp});
        @(negedge clk); eng_tx_pop = 0;
    endtask

    task automatic cpu_rd_chk(input string req, input logic [7:0] exp);
        @(negedge clk); cpu_rx_rd = 1; #0.5;
        chk_eq(req, {24'h0, cpu_rx_data}, {24'h0, exp});
        @(negedge clk); cpu_rx_rd = 0;
    endtask

    task automatic stat_write(input logic [31:0] v);
        @(negedge clk); stat_wr = 1; stat_wdata = v;
        @(negedge clk); stat_wr = 0; stat_wdata = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_eq("R1 status after reset", stat_rdata, 32'h0040_0005);
        chk_eq("R1 tx data after reset", {24'h0, eng_tx_data}, 32'h0);
        chk_eq("R1 rx data after reset", {24'h0, cpu_rx_data}, 32'h0);
    endtask

    task automatic t_tx_order();
        for (int i = 0; i < 5; i++) cpu_wr(8'hA1 + 8'(i));
        chk_eq("R4 tx free after 5", {25'h0, tx_free()}, 32'd59);
        chk_eq("R5 tx empty clear", {31'h0, stat_rdata[2]}, 32'd0);
        for (int i = 0; i < 5; i++) eng_pop_chk("R2 tx order", 8'hA1 + 8'(i));
        chk_eq("R4 tx free drained", {25'h0, tx_free()}, 32'd64);
    endtask

    task automatic t_rx_order();
        for (int i = 0; i < 3; i++) eng_push(8'h30 + 8'(i * 7));
        chk_eq("R4 rx count after 3", {25'h0, rx_cnt()}, 32'd3);
        chk_eq("R5 rx empty clear", {31'h0, stat_rdata[0]}, 32'd0);
        for (int i = 0; i < 3; i++) cpu_rd_chk("R3 rx order", 8'h30 + 8'(i * 7));
        chk_eq("R5 rx empty again", {31'h0, stat_rdata[0]}, 32'd1);
    endtask

    task automatic t_tx_overflow();
        for (int i = 0; i < 64; i++) cpu_wr(8'(i * 3 + 1));
        chk_eq("R5 tx full flag", {28'h0, stat_rdata[3:0]}, 32'h9);
        chk_eq("R4 tx free at full", {25'h0, tx_free()}, 32'd0);
        cpu_wr(8'hEE);
        chk_eq("R6 tx overflow sticky", {31'h0, stat_rdata[7]}, 32'd1);
        chk_eq("R10 summary on ovf", {31'h0, stat_rdata[8]}, 32'd1);
        for (int i = 0; i < 64; i++) eng_pop_chk("R6 contents intact", 8'(i * 3 + 1));
        chk_eq("R5 tx empty after drain", {31'h0, stat_rdata[2]}, 32'd1);
    endtask

    task automatic t_tx_underrun();
        eng_pop_chk("R7 empty pop data zero", 8'h00);
        chk_eq("R7 tx underrun sticky", {31'h0, stat_rdata[6]}, 32'd1);
        chk_eq("R7 level unchanged", {25'h0, tx_free()}, 32'd64);
    endtask

    task automatic t_sticky_clear();
        stat_write(32'h0000_0080);
        chk_eq("R11 keep on 1 clear on 0", {24'h0, stat_rdata[7:0]} & 32'hF0, 32'h80);
        stat_write(32'h0);
        chk_eq("R11 all cleared", {23'h0, stat_rdata[8:4]}, 32'h0);
        chk_eq("R10 summary cleared", {31'h0, stat_rdata[8]}, 32'd0);
    endtask

    task automatic t_rx_overflow();
        for (int i = 0; i < 64; i++) eng_push(8'(8'hFF - i));
        chk_eq("R5 rx full flag", {31'h0, stat_rdata[1]}, 32'd1);
        chk_eq("R4 rx count full", {25'h0, rx_cnt()}, 32'd64);
        eng_push(8'h55);
        chk_eq("R8 rx overflow sticky", {31'h0, stat_rdata[5]}, 32'd1);
        for (int i = 0; i < 64; i++) cpu_rd_chk("R8 contents intact", 8'(8'hFF - i));
    endtask

    task automatic t_rx_underrun();
        cpu_rd_chk("R9 empty read zero", 8'h00);
        chk_eq("R9 rx underrun sticky", {31'h0, stat_rdata[4]}, 32'd1);
        chk_eq("R10 summary with two flags", {31'h0, stat_rdata[8]}, 32'd1);
        stat_write(32'h0);
    endtask

    task automatic t_set_wins();
        for (int i = 0; i < 64; i++) cpu_wr(8'(i));
        @(negedge clk); cpu_tx_wr = 1; cpu_tx_data = 8'h77; stat_wr = 1; stat_wdata = 32'h0;
        @(negedge clk); cpu_tx_wr = 0; stat_wr = 0;
        chk_eq("R11 set beats clear", {31'h0, stat_rdata[7]}, 32'd1);
        stat_write(32'h0);
    endtask

    task automatic t_flush();
        eng_push(8'h11); eng_push(8'h22);
        @(negedge clk); stat_wr = 1; stat_wdata = 32'h0000_4000;
        @(negedge clk); stat_wr = 0; stat_wdata = 0; eng_tx_pop = 1;
        chk_eq("R12 tx flush bit pending", {31'h0, stat_rdata[14]}, 32'd1);
        chk_eq("R12 tx level before flush", {25'h0, tx_free()}, 32'd0);
        @(negedge clk); eng_tx_pop = 0;
        chk_eq("R12 tx flush bit cleared", {31'h0, stat_rdata[14]}, 32'd0);
        chk_eq("R12 tx emptied", {25'h0, tx_free()}, 32'd64);
        chk_eq("R12 pending pop no flag", {31'h0, stat_rdata[6]}, 32'd0);
        chk_eq("R13 rx untouched", {25'h0, rx_cnt()}, 32'd2);
        @(negedge clk); stat_wr = 1; stat_wdata = 32'h0000_8000;
        @(negedge clk); stat_wr = 0; stat_wdata = 0;
        chk_eq("R12 rx flush bit pending", {31'h0, stat_rdata[15]}, 32'd1);
        @(negedge clk);
        chk_eq("R12 rx emptied", {25'h0, rx_cnt()}, 32'd0);
        chk_eq("R12 final status", stat_rdata, 32'h0040_0005);
    endtask

    initial begin
        t_reset();
        t_tx_order();
        t_rx_order();
        t_tx_overflow();
        t_tx_underrun();
        t_sticky_clear();
        t_rx_overflow();
        t_rx_underrun();
        t_set_wins();
        t_flush();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule